// File: doc/BRIEF.md
# Two-Way Set-Indexed Translation Cache with Global Retention

This block keeps recent virtual-to-physical page translations for a 32-bit address with 4 KiB pages. The 20-bit virtual page number is split into a set index, taken from its low bits, and a tag, taken from its high bits. Each of the 16 sets holds two ways. A lookup that hits checks the cached access rights and returns the physical address on the next cycle. The physical address is the cached frame number joined to the untouched 12-bit page offset.

A lookup that misses raises a request to an external table walker and holds it until the walker answers. The block then writes the returned entry into the set and replays the lookup internally. Only one miss is handled at a time: new lookups are refused while a walk or its replay is in progress. A write to an entry whose cached dirty bit is clear also goes out as a walk, so that memory can record the modification. A flush request, used on a task switch, drops every entry that is not marked global. A flush that arrives during a walk is held and carried out once that access has completed.

Top module: `tlb_xlate`

## Requirements
- R1: The set index is vaddr[15:12] and the tag is vaddr[31:16]. Two lines with the same index and different tags can both be resident, and at most one way ever matches a lookup.
- R2: An accepted lookup that hits with sufficient rights makes resp_valid high for one cycle, one clock after acceptance. In that cycle resp_fault is 0 and resp_paddr is {cached frame, vaddr[11:0]}.
- R3: An accepted lookup that misses raises walk_req_valid one clock after acceptance, with walk_req_vpn = vaddr[31:12], and holds it until walk_rsp_valid. When the walker answers with walk_rsp_present=1, the entry is installed and the response (fault 0, correct address) follows two clocks after the walker's answer.
- R4: A hit whose rights forbid the access produces resp_fault=1 with no walk. Rights are forbidden when the access is a write and the entry is not writable, or when it is a user access (req_user=1) and the entry is not user-accessible. A walk answered with walk_rsp_present=0 produces resp_fault=2 and installs nothing.
- R5: A permitted write that hits an entry with a clear cached dirty bit is handled as a miss: it raises a walk with walk_req_write=1, and the returned entry replaces the same way. A read of such an entry is an ordinary hit.
- R6: A flush invalidates every entry with a clear global bit. Entries installed with walk_rsp_global=1 still hit afterwards.
- R7: A fill into a set goes to the least recently used way. Every hit that produces a response, and every fill, marks the used way as most recent. After reset, way 0 is the least recent in every set.
- R8: While a walk or its replay is in progress, req_ready is low. A flush requested during that time is deferred and takes effect after the access completes.
- R9: After reset, all entries are invalid, resp_valid and walk_req_valid are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| resp_valid | output | 1 | Response pulse |
| resp_paddr | output | 32 | Physical address |
| resp_fault | output | 2 | 0 none, 1 protection, 2 page not present |
| flush_req | input | 1 | Task-switch flush of non-global entries |
| walk_req_valid | output | 1 | Walk request, held until answered |
| walk_req_vpn | output | 20 | Page number to walk |
| walk_req_write | output | 1 | Walk caused by a write (sets dirty in memory) |
| walk_rsp_valid | input | 1 | Walker answer strobe |
| walk_rsp_present | input | 1 | Page present |
| walk_rsp_pfn | input | 20 | Frame number |
| walk_rsp_writable | input | 1 | Page may be written |
| walk_rsp_user | input | 1 | Page accessible from user mode |
| walk_rsp_global | input | 1 | Entry survives flush |
| walk_rsp_dirty | input | 1 | Page already dirty |

## Verification
The hardest situation to reach from the ports is a flush that arrives while a walk is pending. The bench's walker model reaches it by holding back its answer and pulsing the flush during the walk. It then shows that the flush took effect afterwards: both the freshly installed line and an older line walk again. Replacement order is reached by a fixed per-set access pattern over all 16 sets, whose hit or miss outcome is worked out in advance. The dirty-bit upgrade is reached by a read fill followed by a write to the same page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_PROT   = 2'd1,
    FLT_ABSENT = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WALK   = 2'd1,
    ST_REPLAY = 2'd2
  } state_e;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 16,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_rw,
  output logic             lk_us,
  output logic             lk_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_rw,
  input  logic             wr_us,
  input  logic             wr_dirty,
  input  logic             wr_glob,
  input  logic             flush_en
);
  localparam int SETS  = 1 << IDX_W;
  localparam int ROW_W = TAG_W + PFN_W + 3;

  logic [ROW_W-1:0] row_mem [SETS];
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  glb_q;
  logic [ROW_W-1:0] row_rd;

  // payload: RAM-style, no reset, read asynchronously (distributed RAM)
  always_ff @(posedge clk) begin
    if (wr_en) row_mem[wr_idx] <= {wr_tag, wr_pfn, wr_rw, wr_us, wr_dirty};
  end

  // valid/global kept in flops so a flush clears all sets at once
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      glb_q <= '0;
    end else if (flush_en) begin
      vld_q <= vld_q & glb_q;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
      glb_q[wr_idx] <= wr_glob;
    end
  end

  assign row_rd   = row_mem[lk_idx];
  assign lk_hit   = vld_q[lk_idx] && (row_rd[ROW_W-1 -: TAG_W] == lk_tag);
  assign lk_pfn   = row_rd[PFN_W+2:3];
  assign lk_rw    = row_rd[2];
  assign lk_us    = row_rd[1];
  assign lk_dirty = row_rd[0];

  AST_FLUSH_DROPS_LOCAL: assert property (@(posedge clk) disable iff (rst)
    flush_en |=> ((vld_q & ~glb_q) == '0)); // R6
  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    flush_en |=> ((vld_q & glb_q) == $past(vld_q & glb_q))); // R6
endmodule

// File: rtl/tlb_lru_bits.sv
module tlb_lru_bits #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst)         lru_q <= '0;
    else if (upd_en) lru_q[upd_idx] <= ~upd_way;
  end

  assign victim = lru_q[rd_idx];

  AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (lru_q[$past(upd_idx)] != $past(upd_way))); // R7
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check (
  input  logic acc_write,
  input  logic acc_user,
  input  logic ent_rw,
  input  logic ent_us,
  input  logic ent_dirty,
  output logic prot_bad,
  output logic need_dirty
);
  assign prot_bad   = (acc_write && !ent_rw) || (acc_user && !ent_us);
  assign need_dirty = acc_write && !ent_dirty;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 4,
  parameter int PFN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  input  logic                   req_user,
  output logic                   req_ready,
  output logic                   resp_valid,
  output logic [PFN_W+OFF_W-1:0] resp_paddr,
  output logic [1:0]             resp_fault,
  input  logic                   flush_req,
  output logic                   walk_req_valid,
  output logic [VA_W-OFF_W-1:0]  walk_req_vpn,
  output logic                   walk_req_write,
  input  logic                   walk_rsp_valid,
  input  logic                   walk_rsp_present,
  input  logic [PFN_W-1:0]       walk_rsp_pfn,
  input  logic                   walk_rsp_writable,
  input  logic                   walk_rsp_user,
  input  logic                   walk_rsp_global,
  input  logic                   walk_rsp_dirty
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAYS  = 2;

  state_e          state_q;
  logic [VA_W-1:0] sav_va_q;
  logic            sav_wr_q;
  logic            sav_us_q;
  logic            flush_pend_q;

  logic            in_idle;
  logic            accept;
  logic            flush_go;
  logic [VA_W-1:0] lk_va;
  logic            lk_wr;
  logic            lk_us;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;

  logic [WAYS-1:0]  hit_vec;
  logic [PFN_W-1:0] way_pfn [WAYS];
  logic [WAYS-1:0]  way_rw;
  logic [WAYS-1:0]  way_us;
  logic [WAYS-1:0]  way_dirty;

  logic             hit_any;
  logic             hit_way;
  logic [PFN_W-1:0] sel_pfn;
  logic             sel_rw;
  logic             sel_us;
  logic             sel_dirty;
  logic             prot_bad;
  logic             need_dirty;
  logic             victim;
  logic             fill_en;
  logic             fill_way;
  logic             lru_upd;
  logic             lru_way;
  logic             hit_reply;

  // ---------------- lookup source ----------------
  assign in_idle   = (state_q == ST_IDLE);
  assign req_ready = in_idle && !flush_req && !flush_pend_q;
  assign accept    = req_valid && req_ready;
  assign flush_go  = in_idle && (flush_req || flush_pend_q);

  assign lk_va  = in_idle ? req_vaddr : sav_va_q;
  assign lk_wr  = in_idle ? req_write : sav_wr_q;
  assign lk_us  = in_idle ? req_user  : sav_us_q;
  assign lk_idx = lk_va[OFF_W +: IDX_W];
  assign lk_tag = lk_va[VA_W-1 -: TAG_W];

  // ---------------- ways ----------------
  assign fill_en  = (state_q == ST_WALK) && walk_rsp_valid && walk_rsp_present;
  assign fill_way = hit_any ? hit_way : victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_store #(
      .IDX_W(IDX_W),
      .TAG_W(TAG_W),
      .PFN_W(PFN_W)
    ) way_i (
      .clk      (clk),
      .rst      (rst),
      .lk_idx   (lk_idx),
      .lk_tag   (lk_tag),
      .lk_hit   (hit_vec[w]),
      .lk_pfn   (way_pfn[w]),
      .lk_rw    (way_rw[w]),
      .lk_us    (way_us[w]),
      .lk_dirty (way_dirty[w]),
      .wr_en    (fill_en && (fill_way == 1'(w))),
      .wr_idx   (lk_idx),
      .wr_tag   (lk_tag),
      .wr_pfn   (walk_rsp_pfn),
      .wr_rw    (walk_rsp_writable),
      .wr_us    (walk_rsp_user),
      .wr_dirty (walk_rsp_dirty),
      .wr_glob  (walk_rsp_global),
      .flush_en (flush_go)
    );
  end

  assign hit_any   = |hit_vec;
  assign hit_way   = hit_vec[1];
  assign sel_pfn   = way_pfn[hit_way];
  assign sel_rw    = way_rw[hit_way];
  assign sel_us    = way_us[hit_way];
  assign sel_dirty = way_dirty[hit_way];

  tlb_perm_check perm_i (
    .acc_write  (lk_wr),
    .acc_user   (lk_us),
    .ent_rw     (sel_rw),
    .ent_us     (sel_us),
    .ent_dirty  (sel_dirty),
    .prot_bad   (prot_bad),
    .need_dirty (need_dirty)
  );

  // ---------------- replacement ----------------
  assign hit_reply = hit_any &&
                     ((accept && (prot_bad || !need_dirty)) || (state_q == ST_REPLAY));
  assign lru_upd   = fill_en || hit_reply;
  assign lru_way   = fill_en ? fill_way : hit_way;

  tlb_lru_bits #(
    .IDX_W(IDX_W)
  ) lru_i (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (lk_idx),
    .victim  (victim),
    .upd_en  (lru_upd),
    .upd_idx (lk_idx),
    .upd_way (lru_way)
  );

  // ---------------- control and registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      sav_va_q       <= '0;
      sav_wr_q       <= 1'b0;
      sav_us_q       <= 1'b0;
      flush_pend_q   <= 1'b0;
      resp_valid     <= 1'b0;
      resp_paddr     <= '0;
      resp_fault     <= FLT_NONE;
      walk_req_valid <= 1'b0;
      walk_req_vpn   <= '0;
      walk_req_write <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      if (flush_go)       flush_pend_q <= 1'b0;
      else if (flush_req) flush_pend_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sav_va_q <= req_vaddr;
            sav_wr_q <= req_write;
            sav_us_q <= req_user;
            if (hit_any && prot_bad) begin
              resp_valid <= 1'b1;
              resp_fault <= FLT_PROT;
              resp_paddr <= {sel_pfn, req_vaddr[OFF_W-1:0]};
            end else if (hit_any && !need_dirty) begin
              resp_valid <= 1'b1;
              resp_fault <= FLT_NONE;
              resp_paddr <= {sel_pfn, req_vaddr[OFF_W-1:0]};
            end else begin
              state_q        <= ST_WALK;
              walk_req_valid <= 1'b1;
              walk_req_vpn   <= req_vaddr[VA_W-1:OFF_W];
              walk_req_write <= req_write;
            end
          end
        end
        ST_WALK: begin
          if (walk_rsp_valid) begin
            walk_req_valid <= 1'b0;
            if (walk_rsp_present) begin
              state_q <= ST_REPLAY;
            end else begin
              resp_valid <= 1'b1;
              resp_fault <= FLT_ABSENT;
              resp_paddr <= '0;
              state_q    <= ST_IDLE;
            end
          end
        end
        ST_REPLAY: begin
          resp_valid <= 1'b1;
          resp_paddr <= {sel_pfn, sav_va_q[OFF_W-1:0]};
          if (!hit_any)      resp_fault <= FLT_ABSENT;
          else if (prot_bad) resp_fault <= FLT_PROT;
          else               resp_fault <= FLT_NONE;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(hit_vec) <= 1); // R1
  AST_HIT_REPLY: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_any && !prot_bad && !need_dirty) |=> (resp_valid && resp_fault == FLT_NONE)); // R2
  AST_PROT_NO_WALK: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_any && prot_bad) |=> (resp_valid && resp_fault == FLT_PROT && !walk_req_valid)); // R4
  AST_DIRTY_WALK: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_any && !prot_bad && need_dirty) |=> (walk_req_valid && walk_req_write)); // R5
  AST_WALK_HELD: assert property (@(posedge clk) disable iff (rst)
    (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn))); // R8
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |-> !req_ready); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!resp_valid && !walk_req_valid)); // R9
endmodule

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        req_ready;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic [1:0]  resp_fault;
  logic        flush_req = 1'b0;
  logic        walk_req_valid;
  logic [19:0] walk_req_vpn;
  logic        walk_req_write;
  logic        walk_rsp_valid = 1'b0;
  logic        walk_rsp_present = 1'b0;
  logic [19:0] walk_rsp_pfn = '0;
  logic        walk_rsp_writable = 1'b0;
  logic        walk_rsp_user = 1'b0;
  logic        walk_rsp_global = 1'b0;
  logic        walk_rsp_dirty = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_user(req_user), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .flush_req(flush_req),
    .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
    .walk_req_write(walk_req_write),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_present(walk_rsp_present),
    .walk_rsp_pfn(walk_rsp_pfn), .walk_rsp_writable(walk_rsp_writable),
    .walk_rsp_user(walk_rsp_user), .walk_rsp_global(walk_rsp_global),
    .walk_rsp_dirty(walk_rsp_dirty)
  );

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // page table model: attributes follow the top nibble of the page number
  function automatic logic [19:0] pfn_of(input logic [19:0] v);
    return v ^ 20'h5A5A5;
  endfunction

  function automatic logic [31:0] pa_of(input logic [31:0] va);
    return {pfn_of(va[31:12]), va[11:0]};
  endfunction

  task automatic access(input logic [31:0] va, input logic wr, input logic us,
                        input bit flush_mid,
                        output bit walked, output logic wwr,
                        output logic [1:0] flt, output logic [31:0] pa);
    walked = 1'b0;
    wwr    = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    req_user  = us;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 40 && !resp_valid; n++) begin
      if (walk_req_valid && !walked) begin
        walked = 1'b1;
        wwr    = walk_req_write;
        check(walk_req_vpn == va[31:12], "R3 walk page number", 64'(walk_req_vpn), 64'(va[31:12]));
        check(!req_ready, "R8 ready low during walk", 64'(req_ready), 64'd0);
        if (flush_mid) begin
          flush_req = 1'b1;
          @(negedge clk);
          flush_req = 1'b0;
          check(!req_ready && walk_req_valid, "R8 flush deferred, walk still held",
                64'({req_ready, walk_req_valid}), 64'b01);
        end
        walk_rsp_present  = (walk_req_vpn[19:16] != 4'hF);
        walk_rsp_pfn      = pfn_of(walk_req_vpn);
        walk_rsp_writable = (walk_req_vpn[19:16] != 4'hE);
        walk_rsp_user     = (walk_req_vpn[19:16] != 4'hD);
        walk_rsp_global   = (walk_req_vpn[19:16] == 4'hC);
        walk_rsp_dirty    = walk_req_write;
        walk_rsp_valid    = 1'b1;
        @(negedge clk);
        walk_rsp_valid    = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    flt = resp_fault;
    pa  = resp_paddr;
    check(resp_valid == 1'b1, "R2 response seen", 64'(resp_valid), 64'd1);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit          w;
    logic        ww;
    logic [1:0]  f;
    logic [31:0] p;
    logic [31:0] va;
    logic [15:0] tg;

    repeat (3) @(negedge clk);
    check(!resp_valid && !walk_req_valid, "R9 outputs quiet in reset",
          64'({resp_valid, walk_req_valid}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'd1);

    // R1 R2 R3 R7: per-set pattern A A B A C A B C A
    // outcome M H M H M H M M M with one-bit LRU starting at way 0
    for (int s = 0; s < 16; s++) begin
      for (int step = 0; step < 9; step++) begin
        bit exp_walk;
        case (step)
          0, 1, 3, 5, 8: tg = 16'h0100 + 16'(s);
          2, 6:          tg = 16'h1200 + 16'(s);
          default:       tg = 16'h2300 + 16'(s);
        endcase
        exp_walk = !(step == 1 || step == 3 || step == 5);
        va = {tg, 4'(s), 12'(s * 37 + step * 5)};
        access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
        check(w == exp_walk, "R7 replacement hit/miss pattern", 64'(w), 64'(exp_walk));
        check(f == 2'd0 && p == pa_of(va), "R2 R3 translated address",
              {30'd0, f, p}, {32'd0, pa_of(va)});
      end
    end

    // R4: rights faults and absent page (set 9)
    va = {16'hE109, 4'd9, 12'h010};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(w && f == 2'd0, "R4 read-only page read fill", 64'({w, f}), 64'b100);
    access(va, 1'b1, 1'b0, 1'b0, w, ww, f, p);
    check(!w && f == 2'd1, "R4 write to read-only faults without walk", 64'({w, f}), 64'b001);
    va = {16'hD109, 4'd9, 12'h020};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(w && f == 2'd0, "R4 supervisor page fill", 64'({w, f}), 64'b100);
    access(va, 1'b0, 1'b1, 1'b0, w, ww, f, p);
    check(!w && f == 2'd1, "R4 user access to supervisor page faults", 64'({w, f}), 64'b001);
    va = {16'hF109, 4'd9, 12'h030};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(w && f == 2'd2, "R4 absent page fault", 64'({w, f}), 64'b110);
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(w && f == 2'd2, "R4 absent page not installed", 64'({w, f}), 64'b110);
    va = {16'hE109, 4'd9, 12'h040};
    access(va, 1'b0, 1'b1, 1'b0, w, ww, f, p);
    check(!w && f == 2'd0 && p == pa_of(va), "R4 resident lines kept after absent page",
          64'({w, f}), 64'b000);

    // R5: dirty upgrade (set 3)
    va = {16'h0533, 4'd3, 12'h111};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(w && !ww, "R5 read fill leaves dirty clear", 64'({w, ww}), 64'b10);
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(!w && f == 2'd0, "R5 read of clean entry hits", 64'({w, f}), 64'b000);
    access(va, 1'b1, 1'b0, 1'b0, w, ww, f, p);
    check(w && ww && f == 2'd0 && p == pa_of(va), "R5 first write walks with write flag",
          64'({w, ww, f}), 64'b1100);
    access(va, 1'b1, 1'b0, 1'b0, w, ww, f, p);
    check(!w && f == 2'd0, "R5 second write hits", 64'({w, f}), 64'b000);

    // R6: flush keeps global (set 5)
    va = {16'hC055, 4'd5, 12'h222};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    va = {16'h0655, 4'd5, 12'h333};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    do_flush();
    va = {16'hC055, 4'd5, 12'h222};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(!w && f == 2'd0 && p == pa_of(va), "R6 global entry survives flush",
          64'({w, f}), 64'b000);
    va = {16'h0655, 4'd5, 12'h333};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(w && f == 2'd0, "R6 local entry removed by flush", 64'({w, f}), 64'b100);

    // R8: flush during a walk is deferred
    va = {16'h0777, 4'd7, 12'h444};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    va = {16'h0888, 4'd8, 12'h555};
    access(va, 1'b0, 1'b0, 1'b1, w, ww, f, p);
    check(w && f == 2'd0 && p == pa_of(va), "R8 access completes across flush",
          64'({w, f}), 64'b100);
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(w, "R8 flush applied after fill", 64'(w), 64'd1);
    va = {16'h0777, 4'd7, 12'h444};
    access(va, 1'b0, 1'b0, 1'b0, w, ww, f, p);
    check(w, "R8 older line flushed", 64'(w), 64'd1);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule